// File: doc/BRIEF.md
# Floating-Point Coefficient Color Converter

This block turns a stream of 10-bit RGB pixels into a luma value and two signed chroma values. The conversion is a 3x3 matrix. Each coefficient is stored in a compact form: a 9-bit two's-complement mantissa and a small exponent field that scales the mantissa by a power of two. The three matrix products for a row are summed at full precision. The block then applies a per-channel attenuation factor. Luma is scaled by a contrast knob and then shifted by a brightness offset. Both chroma channels are scaled by a saturation knob. The result is rounded once and limited to the legal output range.

The pixel input carries a valid strobe. The result comes out four clock cycles later with its own valid strobe, and a new pixel may be accepted on every cycle. Coefficients, attenuation factors and knobs are configuration inputs. Software sets them while the stream is idle. A coefficient exponent code with no defined meaning is decoded as a scale of one, and it sets a sticky error flag.

Top module: `fpcoef_csc`

## Requirements
- R1: Luma-row coefficient slot k (k = 0 red, 1 green, 2 blue) occupies `coef_pack[11k +: 11]`. Bits [8:0] hold the mantissa and bits [10:9] hold an unsigned exponent code n. The coefficient value is mantissa / 256 x 2^-n, so codes 0, 1, 2 and 3 scale by 1, 1/2, 1/4 and 1/8.
- R2: Chroma coefficient j (j = 0..2 for the U row and 3..5 for the V row, with columns red, green, blue) occupies `coef_pack[33 + 12j +: 12]`. Bits [8:0] hold the mantissa and bits [11:9] hold a 3-bit exponent code. Codes 0, 1 and 2 give n = 0, 1, 2. Code 3 gives n = -1, which scales by 2.
- R3: Chroma exponent codes 4 to 7 are decoded as n = 0. An accepted pixel that uses such a code sets `exp_err` from the next cycle. The flag then stays high until reset.
- R4: Mantissas are two's complement with 8 fraction bits. Products are summed with no loss of precision. The final value is rounded only once, to floor(x + 1/2).
- R5: Each channel is multiplied by its own attenuation factor. The factor is unsigned with 1 integer bit and 9 fraction bits, so 512 means 1.0.
- R6: Luma is multiplied by `contrast`, and U and V are multiplied by `saturation`. Both knobs are unsigned with 2 integer bits and 6 fraction bits, so 64 means 1.0.
- R7: `bright` is a two's-complement integer. It is added to luma after the rounded scaling.
- R8: Luma is limited to the range 0..1023.
- R9: U and V are two's complement and are limited to the range -512..511.
- R10: `out_valid` equals `in_valid` from four cycles earlier. Back-to-back pixels each produce one result, in input order.
- R11: While `out_valid` is low, `out_y`, `out_u` and `out_v` keep their last values.
- R12: Reset (active-low, asynchronous) clears `out_valid`, all three outputs and `exp_err` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel strobe |
| in_r | input | 10 | Red sample, unsigned |
| in_g | input | 10 | Green sample, unsigned |
| in_b | input | 10 | Blue sample, unsigned |
| coef_pack | input | 105 | Nine packed coefficients (see R1, R2) |
| atten_y | input | 10 | Luma attenuation, unsigned 1.9 |
| atten_u | input | 10 | U attenuation, unsigned 1.9 |
| atten_v | input | 10 | V attenuation, unsigned 1.9 |
| bright | input | 8 | Luma offset, two's complement |
| contrast | input | 8 | Luma gain, unsigned 2.6 |
| saturation | input | 8 | Chroma gain, unsigned 2.6 |
| out_valid | output | 1 | Result strobe |
| out_y | output | 10 | Luma, unsigned |
| out_u | output | 10 | U chroma, two's complement |
| out_v | output | 10 | V chroma, two's complement |
| exp_err | output | 1 | Sticky flag for an illegal exponent code |

## Verification
The checks on latency, output holding and limiting all assume that the configuration inputs do not change while a pixel is still inside the four pipeline stages. This matters because attenuation and knobs are sampled in later stages than the coefficients. The stimulus therefore changes coefficients, factors and knobs only at least one cycle after the previous result has appeared. The error-flag checks also assume that reset is the only thing that clears the flag. The bench asserts reset mid-run only when no pixel is in flight.

// File: rtl/csc_pkg.sv
package csc_pkg;
    // exponent field widths for the two coefficient classes
    localparam int EXP_NARROW_W = 2;
    localparam int EXP_WIDE_W   = 3;
    // largest left shift applied to a term (n = -1) and the shift meaning n = 0
    localparam int MAX_UP       = 4;
    localparam int UNIT_SH      = 3;
    localparam int SH_W         = 3;
    localparam int N_ROWS       = 3;
    localparam int N_COLS       = 3;

    typedef enum logic [1:0] {
        ROW_LUMA = 2'd0,
        ROW_CU   = 2'd1,
        ROW_CV   = 2'd2
    } row_e;
endpackage

// File: rtl/csc_coef_dec.sv
module csc_coef_dec #(
    parameter int EXP_W = 2,
    parameter int SH_W  = 3
) (
    input  logic [EXP_W-1:0] code_i,
    output logic [SH_W-1:0]  shamt_o,
    output logic             bad_o
);
    localparam logic [SH_W-1:0] UNIT = SH_W'(csc_pkg::UNIT_SH);

    generate
        if (EXP_W == csc_pkg::EXP_NARROW_W) begin : g_unsigned
            // n = code, shift = UNIT - n
            always_comb begin
                shamt_o = UNIT - SH_W'(code_i);
                bad_o   = 1'b0;
            end
        end else begin : g_signed
            always_comb begin
                shamt_o = UNIT;
                bad_o   = 1'b0;
                unique case (code_i)
                    EXP_W'(0): shamt_o = UNIT;
                    EXP_W'(1): shamt_o = UNIT - SH_W'(1);
                    EXP_W'(2): shamt_o = UNIT - SH_W'(2);
                    EXP_W'(3): shamt_o = UNIT + SH_W'(1);
                    default: begin
                        shamt_o = UNIT;
                        bad_o   = 1'b1;
                    end
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/csc_knob_stage.sv
module csc_knob_stage #(
    parameter int ACC_W   = 26,
    parameter int ATT_W   = 10,
    parameter int KNOB_W  = 8,
    parameter int PIX_W   = 10,
    parameter int FRAC_SH = 26,
    parameter bit IS_LUMA = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld3_i,
    input  logic                    ld4_i,
    input  logic signed [ACC_W-1:0] acc_i,
    input  logic [ATT_W-1:0]        att_i,
    input  logic [KNOB_W-1:0]       knob_i,
    input  logic signed [KNOB_W-1:0] offs_i,
    output logic [PIX_W-1:0]        out_o
);
    localparam int SCALE_W = ACC_W + ATT_W + 1 + KNOB_W + 1;
    localparam logic signed [SCALE_W-1:0] HALF = SCALE_W'(64'sd1 <<< (FRAC_SH - 1));
    localparam logic signed [SCALE_W-1:0] HI =
        IS_LUMA ? SCALE_W'((64'sd1 <<< PIX_W) - 1) : SCALE_W'((64'sd1 <<< (PIX_W - 1)) - 1);
    localparam logic signed [SCALE_W-1:0] LO =
        IS_LUMA ? SCALE_W'(0) : SCALE_W'(-(64'sd1 <<< (PIX_W - 1)));

    logic signed [SCALE_W-1:0] prod_d, prod_q, rnd, sum;
    logic [PIX_W-1:0]          lim;

    always_comb begin
        prod_d = SCALE_W'(acc_i)
               * SCALE_W'($signed({1'b0, att_i}))
               * SCALE_W'($signed({1'b0, knob_i}));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     prod_q <= '0;
        else if (ld3_i) prod_q <= prod_d;
    end

    always_comb begin
        rnd = (prod_q + HALF) >>> FRAC_SH;
        sum = rnd + SCALE_W'(offs_i);
        if (sum > HI)      lim = HI[PIX_W-1:0];
        else if (sum < LO) lim = LO[PIX_W-1:0];
        else               lim = sum[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     out_o <= '0;
        else if (ld4_i) out_o <= lim;
    end

    generate
        if (IS_LUMA) begin : g_luma_chk
            a_r8_y_clamp_hi: assert property (@(posedge clk) disable iff (!rst_n)
                (ld4_i && sum > HI) |=> (out_o == HI[PIX_W-1:0]));
            a_r8_y_clamp_lo: assert property (@(posedge clk) disable iff (!rst_n)
                (ld4_i && sum < LO) |=> (out_o == '0));
        end else begin : g_chroma_chk
            a_r9_c_clamp_hi: assert property (@(posedge clk) disable iff (!rst_n)
                (ld4_i && sum > HI) |=> (out_o == HI[PIX_W-1:0]));
            a_r9_c_clamp_lo: assert property (@(posedge clk) disable iff (!rst_n)
                (ld4_i && sum < LO) |=> (out_o == LO[PIX_W-1:0]));
        end
    endgenerate
endmodule

// File: rtl/fpcoef_csc.sv
module fpcoef_csc #(
    parameter int PIX_W     = 10,
    parameter int MANT_W    = 9,
    parameter int MANT_FRAC = 8,
    parameter int ATT_W     = 10,
    parameter int ATT_FRAC  = 9,
    parameter int KNOB_W    = 8,
    parameter int KNOB_FRAC = 6,
    localparam int NSLOT_W  = MANT_W + csc_pkg::EXP_NARROW_W,
    localparam int WSLOT_W  = MANT_W + csc_pkg::EXP_WIDE_W,
    localparam int PACK_W   = csc_pkg::N_COLS * NSLOT_W + 2 * csc_pkg::N_COLS * WSLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_r,
    input  logic [PIX_W-1:0]  in_g,
    input  logic [PIX_W-1:0]  in_b,
    input  logic [PACK_W-1:0] coef_pack,
    input  logic [ATT_W-1:0]  atten_y,
    input  logic [ATT_W-1:0]  atten_u,
    input  logic [ATT_W-1:0]  atten_v,
    input  logic [KNOB_W-1:0] bright,
    input  logic [KNOB_W-1:0] contrast,
    input  logic [KNOB_W-1:0] saturation,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_y,
    output logic [PIX_W-1:0]  out_u,
    output logic [PIX_W-1:0]  out_v,
    output logic              exp_err
);
    import csc_pkg::*;

    localparam int N_COEF   = N_ROWS * N_COLS;
    localparam int TERM_W   = PIX_W + 1 + MANT_W;
    localparam int TERM_X_W = TERM_W + MAX_UP;
    localparam int ACC_W    = TERM_X_W + 2;
    localparam int FRAC_SH  = MANT_FRAC + UNIT_SH + ATT_FRAC + KNOB_FRAC;

    logic [PIX_W-1:0]           pix [N_COLS];
    logic signed [TERM_X_W-1:0] term_q [N_COEF];
    logic signed [ACC_W-1:0]    acc_q [N_ROWS];
    logic [N_COEF-1:0]          bad;
    logic [3:0]                 v_q;
    logic                       err_q;

    assign pix[0] = in_r;
    assign pix[1] = in_g;
    assign pix[2] = in_b;

    // stage 1: decode each coefficient and form its scaled product
    for (genvar k = 0; k < N_COEF; k++) begin : g_coef
        localparam int  ROW  = k / N_COLS;
        localparam int  COL  = k % N_COLS;
        localparam bit  WIDE = (ROW != int'(ROW_LUMA));
        localparam int  EW   = WIDE ? EXP_WIDE_W : EXP_NARROW_W;
        localparam int  LSB  = WIDE ? (N_COLS * NSLOT_W + (k - N_COLS) * WSLOT_W) : (k * NSLOT_W);

        logic signed [MANT_W-1:0]   mant;
        logic [EW-1:0]              code;
        logic [SH_W-1:0]            sh;
        logic signed [TERM_W-1:0]   raw;
        logic signed [TERM_X_W-1:0] term;

        assign mant = coef_pack[LSB +: MANT_W];
        assign code = coef_pack[LSB + MANT_W +: EW];

        csc_coef_dec #(.EXP_W(EW), .SH_W(SH_W)) u_dec (
            .code_i  (code),
            .shamt_o (sh),
            .bad_o   (bad[k])
        );

        always_comb begin
            raw  = TERM_W'($signed({1'b0, pix[COL]})) * TERM_W'(mant);
            term = TERM_X_W'(raw) <<< sh;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        term_q[k] <= '0;
            else if (in_valid) term_q[k] <= term;
        end
    end

    // stage 2: full-precision row sums
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      acc_q[r] <= '0;
            else if (v_q[0]) acc_q[r] <= ACC_W'(term_q[3*r]) + ACC_W'(term_q[3*r+1])
                                       + ACC_W'(term_q[3*r+2]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q   <= '0;
            err_q <= 1'b0;
        end else begin
            v_q <= {v_q[2:0], in_valid};
            if (in_valid && (|bad)) err_q <= 1'b1;
        end
    end

    assign out_valid = v_q[3];
    assign exp_err   = err_q;

    // stages 3 and 4: attenuation, knob gain, offset, rounding and limiting
    csc_knob_stage #(.ACC_W(ACC_W), .ATT_W(ATT_W), .KNOB_W(KNOB_W), .PIX_W(PIX_W),
                     .FRAC_SH(FRAC_SH), .IS_LUMA(1'b1)) u_ky (
        .clk(clk), .rst_n(rst_n), .ld3_i(v_q[1]), .ld4_i(v_q[2]),
        .acc_i(acc_q[0]), .att_i(atten_y), .knob_i(contrast),
        .offs_i($signed(bright)), .out_o(out_y)
    );
    csc_knob_stage #(.ACC_W(ACC_W), .ATT_W(ATT_W), .KNOB_W(KNOB_W), .PIX_W(PIX_W),
                     .FRAC_SH(FRAC_SH), .IS_LUMA(1'b0)) u_ku (
        .clk(clk), .rst_n(rst_n), .ld3_i(v_q[1]), .ld4_i(v_q[2]),
        .acc_i(acc_q[1]), .att_i(atten_u), .knob_i(saturation),
        .offs_i('0), .out_o(out_u)
    );
    csc_knob_stage #(.ACC_W(ACC_W), .ATT_W(ATT_W), .KNOB_W(KNOB_W), .PIX_W(PIX_W),
                     .FRAC_SH(FRAC_SH), .IS_LUMA(1'b0)) u_kv (
        .clk(clk), .rst_n(rst_n), .ld3_i(v_q[1]), .ld4_i(v_q[2]),
        .acc_i(acc_q[2]), .att_i(atten_v), .knob_i(saturation),
        .offs_i('0), .out_o(out_v)
    );

    // cycles since reset, saturating, so the latency check never reaches before reset
    logic [2:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 3'd4)  age_q <= age_q + 3'd1;
    end

    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 3'd4) |-> (out_valid == $past(in_valid, 4)));
    a_r3_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (|bad)) |=> exp_err);
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        exp_err |=> exp_err);
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_y) && $stable(out_u) && $stable(out_v)));
endmodule

// File: tb/tb_fpcoef_csc.sv
module tb_fpcoef_csc;
    localparam int NS = 11;
    localparam int WS = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [9:0]   in_r = '0, in_g = '0, in_b = '0;
    logic [104:0] coef_pack;
    logic         out_valid, exp_err;
    logic [9:0]   out_y, out_u, out_v;

    int cm [9];
    int ce [9];
    int att [3];
    int bri = 0, con = 64, sat = 64;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    always_comb begin
        coef_pack = '0;
        for (int k = 0; k < 3; k++)
            coef_pack[k*NS +: NS] = {ce[k][1:0], cm[k][8:0]};
        for (int k = 3; k < 9; k++)
            coef_pack[3*NS + (k-3)*WS +: WS] = {ce[k][2:0], cm[k][8:0]};
    end

    fpcoef_csc dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_r(in_r), .in_g(in_g), .in_b(in_b), .coef_pack(coef_pack),
        .atten_y(10'(att[0])), .atten_u(10'(att[1])), .atten_v(10'(att[2])),
        .bright(8'(bri)), .contrast(8'(con)), .saturation(8'(sat)),
        .out_valid(out_valid), .out_y(out_y), .out_u(out_u), .out_v(out_v),
        .exp_err(exp_err)
    );

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int shf(int k);
        if (k < 3) return 3 - (ce[k] & 3);
        case (ce[k])
            0: return 3;
            1: return 2;
            2: return 1;
            3: return 4;
            default: return 3;
        endcase
    endfunction

    function automatic longint model(int row, int r, int g, int b);
        longint acc = 0, p, v;
        int px [3];
        int kn;
        px[0] = r; px[1] = g; px[2] = b;
        for (int c = 0; c < 3; c++)
            acc += longint'(px[c]) * longint'(cm[row*3+c]) * (longint'(1) << shf(row*3+c));
        kn = (row == 0) ? con : sat;
        p = acc * longint'(att[row]) * longint'(kn);
        v = (p + (longint'(1) << 25)) >>> 26;
        if (row == 0) begin
            v += bri;
            if (v > 1023) v = 1023;
            if (v < 0) v = 0;
        end else begin
            if (v > 511) v = 511;
            if (v < -512) v = -512;
        end
        return v;
    endfunction

    task automatic set_coefs(int m0, int m1, int m2, int e);
        for (int k = 0; k < 9; k++) begin
            cm[k] = (k % 3 == 0) ? m0 : ((k % 3 == 1) ? m1 : m2);
            ce[k] = e;
        end
    endtask

    task automatic px_check(int r, int g, int b, string tag);
        @(negedge clk);
        in_r = 10'(r); in_g = 10'(g); in_b = 10'(b); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk({tag, " R10 valid"}, longint'(out_valid), 1);
        chk({tag, " y"}, longint'(out_y), model(0, r, g, b));
        chk({tag, " u"}, longint'($signed(out_u)), model(1, r, g, b));
        chk({tag, " v"}, longint'($signed(out_v)), model(2, r, g, b));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        chk("R12 out_valid", longint'(out_valid), 0);
        chk("R12 out_y", longint'(out_y), 0);
        chk("R12 out_u", longint'(out_u), 0);
        chk("R12 out_v", longint'(out_v), 0);
        chk("R12 exp_err", longint'(exp_err), 0);
    endtask

    task automatic t_luma_exp();
        set_coefs(100, 60, 20, 0);
        for (int e = 0; e < 4; e++) begin
            for (int k = 0; k < 3; k++) ce[k] = e;
            px_check(500, 300, 200, "R1 luma exponent");
        end
    endtask

    task automatic t_chroma_exp();
        set_coefs(90, 40, 70, 0);
        for (int e = 0; e < 4; e++) begin
            for (int k = 3; k < 9; k++) ce[k] = e;
            px_check(333, 777, 100, "R2 chroma exponent");
        end
    endtask

    task automatic t_signed();
        set_coefs(77, 150, 29, 1);
        cm[3] = -43; cm[4] = -85; cm[5] = 128;
        cm[6] = 128; cm[7] = -107; cm[8] = -21;
        ce[3] = 3; ce[8] = 2;
        px_check(1023, 0, 0, "R4 signed red");
        px_check(0, 1023, 0, "R4 signed green");
        px_check(0, 0, 1023, "R4 signed blue");
        px_check(1, 3, 1, "R4 rounding");
    endtask

    task automatic t_atten();
        att[0] = 256; att[1] = 1023; att[2] = 100;
        px_check(600, 400, 800, "R5 attenuation");
        att[0] = 512; att[1] = 512; att[2] = 512;
    endtask

    task automatic t_knobs();
        con = 128; sat = 32; bri = -20;
        px_check(600, 400, 800, "R6 R7 knobs a");
        con = 37; sat = 200; bri = 127;
        px_check(210, 900, 55, "R6 R7 knobs b");
        con = 64; sat = 64; bri = 0;
    endtask

    task automatic t_clamp();
        set_coefs(255, 255, 255, 0);
        for (int k = 3; k < 9; k++) ce[k] = 3;
        px_check(1023, 1023, 1023, "R8 R9 clamp high");
        chk("R8 y at max", longint'(out_y), 1023);
        chk("R9 u at max", longint'($signed(out_u)), 511);
        set_coefs(-256, -256, -256, 0);
        for (int k = 3; k < 9; k++) ce[k] = 3;
        px_check(1023, 1023, 1023, "R8 R9 clamp low");
        chk("R8 y at min", longint'(out_y), 0);
        chk("R9 v at min", longint'($signed(out_v)), -512);
    endtask

    task automatic t_illegal();
        set_coefs(60, 60, 60, 1);
        chk("R3 flag clear before", longint'(exp_err), 0);
        ce[4] = 6;
        px_check(400, 500, 600, "R3 illegal code as n=0");
        chk("R3 flag set", longint'(exp_err), 1);
        ce[4] = 1;
        px_check(100, 200, 300, "R3 legal after illegal");
        chk("R3 flag sticky", longint'(exp_err), 1);
        do_reset();
        @(negedge clk);
        chk("R3 R12 flag cleared by reset", longint'(exp_err), 0);
    endtask

    task automatic t_stream();
        int sr [5], sg [5], sb [5];
        set_coefs(70, -30, 110, 1);
        for (int i = 0; i < 5; i++) begin
            sr[i] = 100 + 150*i; sg[i] = 900 - 170*i; sb[i] = 37*i;
        end
        for (int j = 0; j < 9; j++) begin
            @(negedge clk);
            if (j >= 4) begin
                chk("R10 stream valid", longint'(out_valid), 1);
                chk("R10 stream y", longint'(out_y), model(0, sr[j-4], sg[j-4], sb[j-4]));
                chk("R10 stream u", longint'($signed(out_u)), model(1, sr[j-4], sg[j-4], sb[j-4]));
            end else begin
                chk("R10 no early valid", longint'(out_valid), 0);
            end
            if (j < 5) begin
                in_r = 10'(sr[j]); in_g = 10'(sg[j]); in_b = 10'(sb[j]); in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R10 stream ends", longint'(out_valid), 0);
    endtask

    task automatic t_hold();
        logic [9:0] hy, hu, hv;
        set_coefs(50, 90, 30, 0);
        px_check(700, 300, 500, "R11 setup");
        hy = out_y; hu = out_u; hv = out_v;
        in_r = 10'd5; in_g = 10'd1000; in_b = 10'd17;
        repeat (6) @(negedge clk);
        chk("R11 valid low", longint'(out_valid), 0);
        chk("R11 y held", longint'(out_y), longint'(hy));
        chk("R11 u held", longint'(out_u), longint'(hu));
        chk("R11 v held", longint'(out_v), longint'(hv));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        att[0] = 512; att[1] = 512; att[2] = 512;
        set_coefs(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_luma_exp();
        t_chroma_exp();
        t_signed();
        t_atten();
        t_knobs();
        t_clamp();
        t_illegal();
        t_stream();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule